// File: doc/BRIEF.md
# Line-Alternation Switch Pulse Generator

This block produces one short strobe per video line for the switch that flips the colour-difference phase on alternate lines. It watches a line-rate horizontal pulse and, after that pulse ends, emits a single pulse that is re-timed to the block clock. The block clock is the colour subcarrier divided by two and inverted. At that rate one clock period is about 450 ns, so one period sets both the width of the strobe and the spread in its start time.

The horizontal pulse is not related to the block clock. It passes through a short sampling chain. A falling edge counts as seen when the older sample is high and the newer sample is low. The control section then raises the output for a fixed number of clock cycles, one by default. It ignores any further falling edge until the output has dropped again. A synchronous reset clears the sample history and the output.

Top module: `palLinePulse`

## Requirements
- R1: While `rst` is high at a rising clock edge, `pulseOut` is low after that edge and the sample history is cleared. A line input that is high during reset and low after it therefore produces no pulse.
- R2: If `lineIn` is sampled high at rising edge k-1 and low at rising edge k, then `pulseOut` is high after edge k+1. The pulse therefore starts one to two clock periods after the line input goes low.
- R3: With the default pulse length of 1, `pulseOut` stays high for exactly one clock cycle and is low after the following edge.
- R4: A rising edge of `lineIn`, or a steady high or low level, never raises `pulseOut`.
- R5: Every high-to-low transition of `lineIn` gives its own pulse, including transitions only two clock cycles apart (one cycle high, one cycle low). The number of pulses equals the number of line pulses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Half colour-subcarrier clock, inverted; all logic uses its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| lineIn | input | 1 | Line-rate horizontal pulse, active high, asynchronous to `clk` |
| pulseOut | output | 1 | Line-alternation switch strobe, active high |

## Verification
The generator is driven with several kinds of line pattern: long high pulses followed by long low gaps, single-cycle highs and lows alternating as fast as possible, and random run lengths. The long patterns show whether the pulse follows the falling edge and not the rising edge. The fastest alternation shows whether two edges two cycles apart give two separate pulses or one merged pulse. The random runs compare every output cycle against a bench model of the two-sample detection, which catches any error in latency or width. A directed sequence holds the line high through reset and releases it low. It separates a design whose history is really cleared from one that keeps a stale high sample.

// File: rtl/palPulsePkg.sv
package palPulsePkg;

  typedef enum logic {
    ST_IDLE  = 1'b0,
    ST_PULSE = 1'b1
  } pulseState_t;

  typedef struct packed {
    logic start;
    logic stop;
  } pulseStrobes_t;

endpackage

// File: rtl/palPulseDatapath.sv
module palPulseDatapath
  import palPulsePkg::*;
#(
  parameter int SYNC_DEPTH = 2,
  parameter int PULSE_LEN  = 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          lineIn,
  input  pulseStrobes_t strobes,
  output logic          trailEdge,
  output logic          countDone,
  output logic          pulseOut
);

  localparam int CNT_W = (PULSE_LEN > 1) ? $clog2(PULSE_LEN) : 1;
  localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(PULSE_LEN - 1);

  logic [SYNC_DEPTH-1:0] sampleChain;
  logic [CNT_W-1:0]      holdCount;
  logic                  pulseReg;

  // sampling chain: stage 0 takes the raw line, each later stage the one before
  always_ff @(posedge clk) begin
    if (rst) begin
      sampleChain[0] <= 1'b0;
    end else begin
      sampleChain[0] <= lineIn;
    end
  end

  genvar gi;
  generate
    for (gi = 1; gi < SYNC_DEPTH; gi++) begin : gSyncStage
      always_ff @(posedge clk) begin
        if (rst) begin
          sampleChain[gi] <= 1'b0;
        end else begin
          sampleChain[gi] <= sampleChain[gi-1];
        end
      end
    end
  endgenerate

  // older sample high, newer sample low
  assign trailEdge = sampleChain[SYNC_DEPTH-1] & ~sampleChain[SYNC_DEPTH-2];

  always_ff @(posedge clk) begin
    if (rst) begin
      holdCount <= '0;
    end else if (strobes.start) begin
      holdCount <= LOAD_VAL;
    end else if (holdCount != '0) begin
      holdCount <= holdCount - 1'b1;
    end
  end

  assign countDone = (holdCount == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      pulseReg <= 1'b0;
    end else if (strobes.start) begin
      pulseReg <= 1'b1;
    end else if (strobes.stop) begin
      pulseReg <= 1'b0;
    end
  end

  assign pulseOut = pulseReg;

endmodule

// File: rtl/palPulseControl.sv
module palPulseControl
  import palPulsePkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          trailEdge,
  input  logic          countDone,
  output pulseStrobes_t strobes
);

  pulseState_t state;
  pulseState_t stateNext;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
    end else begin
      state <= stateNext;
    end
  end

  always_comb begin
    stateNext     = state;
    strobes.start = 1'b0;
    strobes.stop  = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (trailEdge) begin
          strobes.start = 1'b1;
          stateNext     = ST_PULSE;
        end
      end
      ST_PULSE: begin
        // edges arriving while the strobe is high are not acted on
        if (countDone) begin
          strobes.stop = 1'b1;
          stateNext    = ST_IDLE;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

endmodule

// File: rtl/palLinePulse.sv
module palLinePulse
  import palPulsePkg::*;
#(
  parameter int SYNC_DEPTH = 2,
  parameter int PULSE_LEN  = 1
) (
  input  logic clk,
  input  logic rst,
  input  logic lineIn,
  output logic pulseOut
);

  pulseStrobes_t strobes;
  logic          trailEdge;
  logic          countDone;

  palPulseDatapath #(
    .SYNC_DEPTH(SYNC_DEPTH),
    .PULSE_LEN (PULSE_LEN)
  ) i_datapath (
    .clk      (clk),
    .rst      (rst),
    .lineIn   (lineIn),
    .strobes  (strobes),
    .trailEdge(trailEdge),
    .countDone(countDone),
    .pulseOut (pulseOut)
  );

  palPulseControl i_control (
    .clk      (clk),
    .rst      (rst),
    .trailEdge(trailEdge),
    .countDone(countDone),
    .strobes  (strobes)
  );

endmodule

// File: rtl/palLinePulseChecker.sv
module palLinePulseChecker #(
  parameter int SYNC_DEPTH = 2,
  parameter int PULSE_LEN  = 1
) (
  input logic clk,
  input logic rst,
  input logic lineIn,
  input logic pulseOut
);

  logic       started = 1'b0;
  logic [1:0] sinceRst = 2'd0;

  always_ff @(posedge clk) begin
    started <= 1'b1;
    if (rst) begin
      sinceRst <= 2'd0;
    end else if (sinceRst != 2'd3) begin
      sinceRst <= sinceRst + 2'd1;
    end
  end

  // R1: the edge after a sampled reset leaves the strobe low
  assert_reset_clears_R1: assert property (@(posedge clk)
    (started && $past(rst)) |-> !pulseOut);

  generate
    if (SYNC_DEPTH == 2 && PULSE_LEN == 1) begin : gDefaultTiming
      // R2: high then low samples give a strobe one edge later
      assert_fall_makes_pulse_R2: assert property (@(posedge clk) disable iff (rst)
        (sinceRst == 2'd3 && $past(lineIn, 2) && !$past(lineIn)) |=> pulseOut);

      // R3: strobe lasts a single cycle
      assert_single_cycle_R3: assert property (@(posedge clk) disable iff (rst)
        pulseOut |=> !pulseOut);

      // R4: low then high samples never give a strobe
      assert_rise_no_pulse_R4: assert property (@(posedge clk) disable iff (rst)
        (sinceRst == 2'd3 && !$past(lineIn, 2) && $past(lineIn)) |=> !pulseOut);

      // R2, R4: every strobe start traces back to a high-then-low sample pair
      assert_pulse_has_cause_R2: assert property (@(posedge clk) disable iff (rst)
        (sinceRst == 2'd3 && $rose(pulseOut)) |-> ($past(lineIn, 3) && !$past(lineIn, 2)));
    end
  endgenerate

endmodule

bind palLinePulse palLinePulseChecker #(
  .SYNC_DEPTH(SYNC_DEPTH),
  .PULSE_LEN (PULSE_LEN)
) i_checker (
  .clk     (clk),
  .rst     (rst),
  .lineIn  (lineIn),
  .pulseOut(pulseOut)
);

// File: tb/test_palLinePulse.sv
module test_palLinePulse;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic lineIn = 1'b0;
  logic pulseOut;

  always #2.5 clk = ~clk;

  palLinePulse i_palLinePulse (
    .clk     (clk),
    .rst     (rst),
    .lineIn  (lineIn),
    .pulseOut(pulseOut)
  );

  int  checks = 0;
  int  errors = 0;
  int  pulseCount = 0;
  int  fallCount = 0;
  bit  monitorOn = 1'b0;
  bit  done = 1'b0;
  logic older = 1'b0, newer = 1'b0, expPulse = 1'b0, prevExp = 1'b0, lastPulse = 1'b0;

  // expected strobe after an edge, from the samples of the two edges before it
  function automatic logic expectFrom(input logic rstNow, input logic o, input logic n);
    return rstNow ? 1'b0 : (o & ~n);
  endfunction

  always @(posedge clk) begin
    prevExp  <= expPulse;
    expPulse <= expectFrom(rst, older, newer);
    older    <= rst ? 1'b0 : newer;
    newer    <= rst ? 1'b0 : lineIn;
  end

  always @(negedge clk) begin
    if (monitorOn) begin
      checks++;
      if (pulseOut !== expPulse) begin
        errors++;
        $display("FAIL %s cycle model: pulseOut=%b expected=%b at %0t",
                 expPulse ? "R2" : (prevExp ? "R3" : "R4"), pulseOut, expPulse, $time);
      end
      if (pulseOut === 1'b1 && lastPulse !== 1'b1) pulseCount++;
      lastPulse = pulseOut;
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic hold(input logic v, input int cycles);
    @(negedge clk);
    if (lineIn === 1'b1 && v === 1'b0) fallCount++;
    lineIn = v;
    repeat (cycles - 1) @(negedge clk);
  endtask

  task automatic summary;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      $display("FAIL R2 watchdog expired actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    int seedDummy;
    int p0, f0;
    seedDummy = $urandom(32'h5A17);

    // R1: reset state, line held high during reset
    lineIn = 1'b1;
    repeat (4) @(negedge clk);
    monitorOn = 1'b1;
    check("R1 reset output", int'(pulseOut), 0);
    @(negedge clk);
    rst = 1'b0;
    lineIn = 1'b0;
    repeat (5) @(negedge clk);
    check("R1 no pulse after reset release", pulseCount, 0);

    // R2, R3: long line pulse, long gap
    p0 = pulseCount; f0 = fallCount;
    hold(1'b1, 6); hold(1'b0, 10);
    check("R2 long line gives pulse", pulseCount - p0, 1);
    check("R3 pulse count vs falls", pulseCount - p0, fallCount - f0);

    // R4: rising edge and steady high give nothing
    p0 = pulseCount;
    hold(1'b1, 12);
    check("R4 rise and steady high", pulseCount - p0, 0);
    hold(1'b0, 6);

    // R5: fastest alternation, one high one low
    p0 = pulseCount; f0 = fallCount;
    for (int i = 0; i < 20; i++) begin
      hold(1'b1, 1); hold(1'b0, 1);
    end
    hold(1'b0, 4);
    check("R5 fastest alternation pulse count", pulseCount - p0, 20);
    check("R5 pulses equal falls", pulseCount - p0, fallCount - f0);

    // R5: line-like pattern
    p0 = pulseCount; f0 = fallCount;
    for (int i = 0; i < 30; i++) begin
      hold(1'b1, 3); hold(1'b0, 17);
    end
    hold(1'b0, 4);
    check("R5 line pattern pulse count", pulseCount - p0, 30);

    // R1: reset in the middle of a pulse
    hold(1'b1, 3);
    hold(1'b0, 2);
    rst = 1'b1;
    @(negedge clk);
    check("R1 reset clears pulse", int'(pulseOut), 0);
    @(negedge clk);
    rst = 1'b0;
    hold(1'b0, 4);

    // random run lengths, cycle model checked every cycle (R2, R3, R4)
    p0 = pulseCount; f0 = fallCount;
    for (int i = 0; i < 1500; i++) begin
      hold(1'($urandom_range(0, 1)), int'($urandom_range(1, 6)));
    end
    hold(1'b0, 5);
    check("R5 random pulses equal falls", pulseCount - p0, fallCount - f0);

    monitorOn = 1'b0;
    done = 1'b1;
    summary();
    $finish;
  end

endmodule